// File: doc/BRIEF.md
# Stepped Load/Store Processor Core

A 32-bit multi-cycle processor for a small teaching instruction set. It holds eight general-purpose registers, a program counter and zero/negative flags, and runs programs out of a 256-word internal memory. Each instruction takes two enabled cycles: one fetches the word at the program counter into the instruction register, and the next executes it. Arithmetic, register moves, immediate loads, memory loads and stores, conditional and unconditional branches, and a trap instruction are supported. The trap's action is picked by the value in register 1. It can stop the core, wait for a keyboard integer, or present a memory word on the display output. The last memory cell serves as the I/O cell.

A host loads programs and reads results through a dedicated memory port. The host writes the program while `step_en_i` is low, releases reset, then raises `step_en_i`. The core then runs until it reports `halted_o`. If it reports `waiting_o`, it needs a keyboard value first. Single-stepping is done by pulsing `step_en_i`.

Top module: `step_cpu`

## Requirements
- R1: After reset the program counter is 0, `halted_o`, `waiting_o` and `disp_strobe_o` are low, the flags and all registers are 0, and the first fetch reads address 0.
- R2: The core advances only on cycles with `step_en_i` high, one cycle to fetch and one to execute. The single exception is a keyboard completion while waiting. With `step_en_i` low, no register, memory cell or program counter changes.
- R3: The opcode is in bits [31:24], in decimal: noop 1, add 10, subcc 21, mul 39. For add, subcc and mul, the first source is in bits [18:16], the second source in bits [10:8] and the destination in bits [2:0]. add and subcc wrap modulo 2^32. mul keeps the low 32 bits of the product. Any register may be both source and destination.
- R4: Only subcc (21) updates the flags. Z is set when first source minus second source is 0, and N is set when that result's bit 31 is 1. All other instructions leave both flags unchanged.
- R5: ba (80) always jumps, be (81) jumps when Z is set, bne (82) when Z is clear, bl (83) when N is set, and bge (84) when N is clear. The target address is in bits [7:0]. A branch that is not taken continues at PC+1.
- R6: ld (70) loads the cell at the address in bits [15:8] into the register in bits [2:0]. st (71) writes the register in bits [2:0] to the cell at the address in bits [15:8]. mov (78) copies the register in bits [18:16] into the register in bits [2:0] and leaves the source unchanged. set (79) writes the sign-extended 16-bit immediate in bits [23:8] into the register in bits [2:0].
- R7: ta (90) with register 1 equal to 0 or 1 stops the core. `halted_o` goes high and stays high until reset, and no further instruction executes.
- R8: ta with register 1 equal to 3 holds the core in a waiting state with `waiting_o` high and the PC unchanged. On the first cycle with `kbd_valid_i` high, it writes `kbd_data_i` to cell 255 and resumes at PC+1.
- R9: ta with register 1 equal to 4 places cell 255 on `disp_data_o` and raises `disp_strobe_o` for exactly one cycle. `disp_data_o` then holds that value.
- R10: ta with any other value in register 1, and any opcode not listed, acts as a no-op and advances the PC by one.
- R11: `host_rdata_o` shows the cell at `host_addr_i` combinationally. A cycle with `host_we_i` high writes `host_wdata_i` to that cell at the clock edge and takes priority over a core write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Lets the core advance on this cycle |
| host_we_i | input | 1 | Host memory write enable |
| host_addr_i | input | 8 | Host memory address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, combinational |
| kbd_data_i | input | 32 | Keyboard integer |
| kbd_valid_i | input | 1 | Keyboard integer valid, completes a pending input trap |
| disp_data_o | output | 32 | Last value sent to the display |
| disp_strobe_o | output | 1 | One-cycle pulse when `disp_data_o` is updated |
| halted_o | output | 1 | Core has stopped |
| waiting_o | output | 1 | Core is waiting for a keyboard value |

## Verification
The in-RTL assertions cover several properties on every cycle. The stop state is sticky. The display strobe never lasts two cycles. The flags hold on every cycle that does not execute subcc. The PC and state freeze while stepping is disabled, and also while a keyboard wait sees no valid pulse. Arithmetic results, sign extension, branch decisions, memory traffic and the trap actions only show up when the bench runs programs. These programs write their results into memory, and the bench reads them back through the host port and compares them with values worked out by hand.

// File: rtl/step_cpu_pkg.sv
package step_cpu_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [7:0] {
    OP_NOOP  = 8'd1,
    OP_ADD   = 8'd10,
    OP_SUBCC = 8'd21,
    OP_MUL   = 8'd39,
    OP_LD    = 8'd70,
    OP_ST    = 8'd71,
    OP_MOV   = 8'd78,
    OP_SET   = 8'd79,
    OP_BA    = 8'd80,
    OP_BE    = 8'd81,
    OP_BNE   = 8'd82,
    OP_BL    = 8'd83,
    OP_BGE   = 8'd84,
    OP_TA    = 8'd90
  } opcode_e;

  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_WAIT, ST_HALT} cstate_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_MUL} alu_op_e;

  localparam logic [WORD_W-1:0] TRAP_STOP_Z = 32'd0;
  localparam logic [WORD_W-1:0] TRAP_STOP   = 32'd1;
  localparam logic [WORD_W-1:0] TRAP_KBD    = 32'd3;
  localparam logic [WORD_W-1:0] TRAP_DISP   = 32'd4;
endpackage

// File: rtl/step_cpu_mem.sv
module step_cpu_mem #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_a_i,
  output logic [WIDTH-1:0] rdata_a_o,
  input  logic [AW-1:0]    raddr_b_i,
  output logic [WIDTH-1:0] rdata_b_o
);
  logic [WIDTH-1:0] cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = cells_q[raddr_a_i];
  assign rdata_b_o = cells_q[raddr_b_i];
endmodule

// File: rtl/step_cpu_regfile.sv
module step_cpu_regfile #(
  parameter int NUM   = 8,
  parameter int WIDTH = 32,
  localparam int RW = $clog2(NUM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [RW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [RW-1:0]    ra_i,
  input  logic [RW-1:0]    rb_i,
  input  logic [RW-1:0]    rc_i,
  output logic [WIDTH-1:0] rdata_a_o,
  output logic [WIDTH-1:0] rdata_b_o,
  output logic [WIDTH-1:0] rdata_c_o
);
  logic [WIDTH-1:0] regs_q [NUM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[ra_i];
  assign rdata_b_o = regs_q[rb_i];
  assign rdata_c_o = regs_q[rc_i];
endmodule

// File: rtl/step_cpu_alu.sv
module step_cpu_alu
  import step_cpu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             neg_o
);
  always_comb begin
    case (op_i)
      ALU_SUB: res_o = a_i - b_i;
      ALU_MUL: res_o = a_i * b_i;  // low half is sign-agnostic
      default: res_o = a_i + b_i;
    endcase
  end

  assign zero_o = (res_o == '0);
  assign neg_o  = res_o[WIDTH-1];
endmodule

// File: rtl/step_cpu.sv
module step_cpu
  import step_cpu_pkg::*;
#(
  parameter int MEM_DEPTH = 256,
  parameter int NUM_REGS  = 8,
  localparam int AW = $clog2(MEM_DEPTH),
  localparam int RW = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              host_we_i,
  input  logic [AW-1:0]     host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic [WORD_W-1:0] host_rdata_o,
  input  logic [WORD_W-1:0] kbd_data_i,
  input  logic              kbd_valid_i,
  output logic [WORD_W-1:0] disp_data_o,
  output logic              disp_strobe_o,
  output logic              halted_o,
  output logic              waiting_o
);
  localparam logic [AW-1:0] IO_ADDR = AW'(MEM_DEPTH - 1);

  cstate_e             state_q;
  logic [AW-1:0]       pc_q;
  logic [WORD_W-1:0]   ir_q;
  logic                flag_z_q, flag_n_q;
  logic [WORD_W-1:0]   disp_q;
  logic                strobe_q;

  opcode_e             opc;
  logic                exec_go, st_go, kbd_go, br_taken;
  logic [RW-1:0]       rf_ra;
  logic [WORD_W-1:0]   rf_a, rf_b, rf_c;
  logic                rf_we;
  logic [WORD_W-1:0]   rf_wd;
  alu_op_e             alu_sel;
  logic [WORD_W-1:0]   alu_res;
  logic                alu_z, alu_n;
  logic [AW-1:0]       core_raddr, mem_waddr;
  logic [WORD_W-1:0]   core_rdata, mem_wdata;
  logic                mem_we;

  assign opc     = opcode_e'(ir_q[31:24]);
  assign exec_go = (state_q == ST_EXEC) && step_en_i;
  assign st_go   = exec_go && (opc == OP_ST);
  assign kbd_go  = (state_q == ST_WAIT) && kbd_valid_i;
  assign rf_ra   = (opc == OP_ST) ? ir_q[0 +: RW] : ir_q[16 +: RW];

  step_cpu_regfile #(.NUM(NUM_REGS), .WIDTH(WORD_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(ir_q[0 +: RW]), .wdata_i(rf_wd),
    .ra_i(rf_ra), .rb_i(ir_q[8 +: RW]), .rc_i(RW'(1)),
    .rdata_a_o(rf_a), .rdata_b_o(rf_b), .rdata_c_o(rf_c)
  );

  always_comb begin
    case (opc)
      OP_SUBCC: alu_sel = ALU_SUB;
      OP_MUL:   alu_sel = ALU_MUL;
      default:  alu_sel = ALU_ADD;
    endcase
  end

  step_cpu_alu #(.WIDTH(WORD_W)) u_alu (
    .op_i(alu_sel), .a_i(rf_a), .b_i(rf_b),
    .res_o(alu_res), .zero_o(alu_z), .neg_o(alu_n)
  );

  always_comb begin
    rf_we = 1'b0;
    rf_wd = alu_res;
    case (opc)
      OP_ADD, OP_SUBCC, OP_MUL: rf_we = exec_go;
      OP_LD:  begin rf_we = exec_go; rf_wd = core_rdata; end
      OP_MOV: begin rf_we = exec_go; rf_wd = rf_a; end
      OP_SET: begin rf_we = exec_go; rf_wd = {{16{ir_q[23]}}, ir_q[23:8]}; end
      default: ;
    endcase
  end

  // one core read port: fetch address, load address, or the I/O cell
  always_comb begin
    if (state_q != ST_EXEC)  core_raddr = pc_q;
    else if (opc == OP_LD)   core_raddr = ir_q[8 +: AW];
    else                     core_raddr = IO_ADDR;
  end

  assign mem_we    = host_we_i | st_go | kbd_go;
  assign mem_waddr = host_we_i ? host_addr_i  : (st_go ? ir_q[8 +: AW] : IO_ADDR);
  assign mem_wdata = host_we_i ? host_wdata_i : (st_go ? rf_a : kbd_data_i);

  step_cpu_mem #(.DEPTH(MEM_DEPTH), .WIDTH(WORD_W)) u_mem (
    .clk_i,
    .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_a_i(core_raddr), .rdata_a_o(core_rdata),
    .raddr_b_i(host_addr_i), .rdata_b_o(host_rdata_o)
  );

  always_comb begin
    case (opc)
      OP_BA:   br_taken = 1'b1;
      OP_BE:   br_taken = flag_z_q;
      OP_BNE:  br_taken = !flag_z_q;
      OP_BL:   br_taken = flag_n_q;
      OP_BGE:  br_taken = !flag_n_q;
      default: br_taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      flag_z_q <= 1'b0;
      flag_n_q <= 1'b0;
      disp_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= 1'b0;
      case (state_q)
        ST_FETCH: if (step_en_i) begin
          ir_q    <= core_rdata;
          state_q <= ST_EXEC;
        end
        ST_EXEC: if (step_en_i) begin
          state_q <= ST_FETCH;
          pc_q    <= br_taken ? ir_q[0 +: AW] : pc_q + 1'b1;
          if (opc == OP_SUBCC) begin
            flag_z_q <= alu_z;
            flag_n_q <= alu_n;
          end
          if (opc == OP_TA) begin
            case (rf_c)
              TRAP_STOP_Z, TRAP_STOP: begin state_q <= ST_HALT; pc_q <= pc_q; end
              TRAP_KBD:  begin state_q <= ST_WAIT; pc_q <= pc_q; end
              TRAP_DISP: begin disp_q <= core_rdata; strobe_q <= 1'b1; end
              default: ;
            endcase
          end
        end
        ST_WAIT: if (kbd_valid_i) begin
          pc_q    <= pc_q + 1'b1;
          state_q <= ST_FETCH;
        end
        default: ;
      endcase
    end
  end

  assign disp_data_o   = disp_q;
  assign disp_strobe_o = strobe_q;
  assign halted_o      = (state_q == ST_HALT);
  assign waiting_o     = (state_q == ST_WAIT);

  assert_step_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_en_i && !waiting_o) |=> ($stable(pc_q) && $stable(state_q)));

  assert_flags_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_go && opc == OP_SUBCC) |=> $stable({flag_z_q, flag_n_q}));

  assert_halt_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_kbd_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o && !kbd_valid_i) |=> (waiting_o && $stable(pc_q)));

  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_strobe_o |=> !disp_strobe_o);
endmodule

// File: tb/step_cpu_test.sv
module step_cpu_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] C_NOOP = 8'd1, C_ADD = 8'd10, C_SUB = 8'd21, C_MUL = 8'd39;
  localparam logic [7:0] C_LD = 8'd70, C_ST = 8'd71, C_MOV = 8'd78, C_SET = 8'd79;
  localparam logic [7:0] C_BA = 8'd80, C_BE = 8'd81, C_BNE = 8'd82, C_BL = 8'd83;
  localparam logic [7:0] C_BGE = 8'd84, C_TA = 8'd90;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [31:0] kbd_data = '0;
  logic        kbd_valid = 1'b0;
  logic [31:0] disp_data;
  logic        disp_strobe, halted, waiting;

  int n_chk = 0, n_fail = 0;
  int strobe_cnt = 0;
  logic [31:0] strobe_val = '0;
  logic [31:0] prog [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  step_cpu uut (
    .clk_i(clk), .rst_ni(rst_n), .step_en_i(step_en),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .kbd_data_i(kbd_data), .kbd_valid_i(kbd_valid),
    .disp_data_o(disp_data), .disp_strobe_o(disp_strobe),
    .halted_o(halted), .waiting_o(waiting)
  );

  always @(negedge clk) if (disp_strobe) begin
    strobe_cnt++;
    strobe_val = disp_data;
  end

  function automatic logic [31:0] i_r(logic [7:0] op, int a, int b, int c);
    return {op, 8'(a), 8'(b), 8'(c)};
  endfunction
  function automatic logic [31:0] i_set(int imm, int rd);
    return {C_SET, 16'(imm), 8'(rd)};
  endfunction
  function automatic logic [31:0] i_mem(logic [7:0] op, int addr, int rg);
    return {op, 8'd0, 8'(addr), 8'(rg)};
  endfunction
  function automatic logic [31:0] i_br(logic [7:0] op, int tgt);
    return {op, 16'd0, 8'(tgt)};
  endfunction
  function automatic logic [31:0] i_ta();
    return {C_TA, 24'd0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    step_en = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic host_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 8'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    host_addr = 8'(a);
    #1 d = host_rdata;
  endtask

  task automatic load_prog(input int n);
    for (int i = 0; i < n; i++) host_wr(i, prog[i]);
  endtask

  task automatic run_until_stop();
    step_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (halted || waiting) break;
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "halted after reset", {31'd0, halted}, 32'd0);
    chk("R1", "waiting after reset", {31'd0, waiting}, 32'd0);
    chk("R1", "strobe after reset", {31'd0, disp_strobe}, 32'd0);
  endtask

  task automatic t_step_gate();
    logic [31:0] d;
    do_reset();
    prog[0] = i_set(9, 2);
    prog[1] = i_mem(C_ST, 231, 2);
    prog[2] = i_set(1, 1);
    prog[3] = i_ta();
    load_prog(4);
    host_wr(231, 32'd0);
    repeat (30) @(negedge clk);
    host_rd(231, d);
    chk("R2", "cell untouched while step disabled", d, 32'd0);
    chk("R2", "no halt while step disabled", {31'd0, halted}, 32'd0);
    run_until_stop();
    host_rd(231, d);
    chk("R1", "program runs from address 0", d, 32'd9);
  endtask

  task automatic t_arith();
    logic [31:0] d;
    logic [31:0] exp [8];
    do_reset();
    prog[0]  = i_set(5, 2);
    prog[1]  = i_set(-1, 3);
    prog[2]  = i_r(C_ADD, 2, 3, 4);
    prog[3]  = i_r(C_MUL, 2, 3, 5);
    prog[4]  = i_mem(C_LD, 200, 6);
    prog[5]  = i_mem(C_LD, 201, 7);
    prog[6]  = i_r(C_ADD, 6, 7, 6);
    prog[7]  = i_r(C_MOV, 2, 0, 0);
    prog[8]  = i_mem(C_ST, 210, 4);
    prog[9]  = i_mem(C_ST, 211, 5);
    prog[10] = i_mem(C_ST, 212, 6);
    prog[11] = i_mem(C_ST, 213, 0);
    prog[12] = i_mem(C_ST, 214, 2);
    prog[13] = i_r(C_MUL, 2, 2, 2);
    prog[14] = i_mem(C_ST, 215, 2);
    prog[15] = i_set(-32768, 3);
    prog[16] = i_mem(C_ST, 216, 3);
    prog[17] = i_mem(C_LD, 202, 4);
    prog[18] = i_r(C_MUL, 4, 4, 5);
    prog[19] = i_mem(C_ST, 217, 5);
    prog[20] = i_set(1, 1);
    prog[21] = i_ta();
    load_prog(22);
    host_wr(200, 32'hFFFF_FFFF);
    host_wr(201, 32'd1);
    host_wr(202, 32'h0001_0001);
    run_until_stop();
    chk("R7", "halt on trap value 1", {31'd0, halted}, 32'd1);
    exp = '{32'd4, 32'hFFFF_FFFB, 32'd0, 32'd5, 32'd5, 32'd25, 32'hFFFF_8000, 32'h0002_0001};
    for (int i = 0; i < 8; i++) begin
      host_rd(210 + i, d);
      if (i < 3 || i == 5 || i == 7) chk("R3", $sformatf("arith cell %0d", 210 + i), d, exp[i]);
      else chk("R6", $sformatf("move/set cell %0d", 210 + i), d, exp[i]);
    end
  endtask

  task automatic t_branch();
    logic [31:0] d;
    logic [31:0] exp [10];
    do_reset();
    prog[0]  = i_set(3, 2);
    prog[1]  = i_set(5, 3);
    prog[2]  = i_set(1, 7);
    prog[3]  = i_r(C_SUB, 2, 3, 4);
    prog[4]  = i_r(C_ADD, 2, 2, 5);
    prog[5]  = i_br(C_BL, 7);
    prog[6]  = i_mem(C_ST, 220, 7);
    prog[7]  = i_br(C_BE, 9);
    prog[8]  = i_mem(C_ST, 221, 7);
    prog[9]  = i_br(C_BNE, 11);
    prog[10] = i_mem(C_ST, 222, 7);
    prog[11] = i_br(C_BGE, 13);
    prog[12] = i_mem(C_ST, 223, 7);
    prog[13] = i_r(C_SUB, 2, 2, 4);
    prog[14] = i_br(C_BE, 16);
    prog[15] = i_mem(C_ST, 224, 7);
    prog[16] = i_br(C_BGE, 18);
    prog[17] = i_mem(C_ST, 225, 7);
    prog[18] = i_br(C_BL, 20);
    prog[19] = i_mem(C_ST, 226, 7);
    prog[20] = i_br(C_BNE, 22);
    prog[21] = i_mem(C_ST, 227, 7);
    prog[22] = i_r(C_SUB, 3, 2, 4);
    prog[23] = i_br(C_BA, 25);
    prog[24] = i_mem(C_ST, 228, 7);
    prog[25] = i_mem(C_ST, 229, 4);
    prog[26] = i_set(1, 1);
    prog[27] = i_ta();
    load_prog(28);
    for (int i = 220; i < 230; i++) host_wr(i, 32'd0);
    run_until_stop();
    exp = '{32'd0, 32'd1, 32'd0, 32'd1, 32'd0, 32'd0, 32'd1, 32'd1, 32'd0, 32'd2};
    for (int i = 0; i < 10; i++) begin
      host_rd(220 + i, d);
      if (i == 0) chk("R4", "N from subcc survives add; bl taken", d, exp[i]);
      else if (i == 9) chk("R3", "subcc result 5-3", d, exp[i]);
      else chk("R5", $sformatf("branch marker %0d", 220 + i), d, exp[i]);
    end
  endtask

  task automatic t_trap_io();
    logic [31:0] d;
    int stuck;
    do_reset();
    strobe_cnt = 0;
    prog[0]  = i_set(7, 1);
    prog[1]  = i_ta();
    prog[2]  = {8'd5, 24'hFFFFFF};
    prog[3]  = {C_NOOP, 24'd0};
    prog[4]  = i_set(3, 1);
    prog[5]  = i_ta();
    prog[6]  = i_mem(C_LD, 255, 2);
    prog[7]  = i_r(C_ADD, 2, 2, 2);
    prog[8]  = i_mem(C_ST, 255, 2);
    prog[9]  = i_set(4, 1);
    prog[10] = i_ta();
    prog[11] = i_set(0, 1);
    prog[12] = i_ta();
    prog[13] = i_mem(C_ST, 240, 2);
    load_prog(14);
    host_wr(240, 32'd0);
    run_until_stop();
    chk("R10", "unlisted trap and opcode pass through", {31'd0, waiting}, 32'd1);
    stuck = 0;
    repeat (6) begin
      @(negedge clk);
      if (waiting) stuck++;
    end
    chk("R8", "stays waiting without valid", 32'(stuck), 32'd6);
    kbd_data = 32'd21; kbd_valid = 1'b1;
    @(negedge clk);
    kbd_valid = 1'b0;
    chk("R8", "wait released by valid", {31'd0, waiting}, 32'd0);
    run_until_stop();
    chk("R7", "halt on trap value 0", {31'd0, halted}, 32'd1);
    chk("R9", "one display strobe", 32'(strobe_cnt), 32'd1);
    chk("R9", "display value doubled input", strobe_val, 32'd42);
    chk("R9", "display holds value", disp_data, 32'd42);
    host_rd(255, d);
    chk("R8", "I/O cell after keyboard path", d, 32'd42);
  endtask

  task automatic t_halt_sticky();
    logic [31:0] d;
    int held;
    do_reset();
    prog[0] = i_set(1, 1);
    prog[1] = i_ta();
    prog[2] = i_mem(C_ST, 230, 1);
    load_prog(3);
    host_wr(230, 32'd0);
    run_until_stop();
    held = 0;
    repeat (20) begin
      @(negedge clk);
      if (halted) held++;
    end
    chk("R7", "halt held", 32'(held), 32'd20);
    host_rd(230, d);
    chk("R7", "no execution after halt", d, 32'd0);
    host_wr(230, 32'hA5A5_0001);
    host_rd(230, d);
    chk("R11", "host write/read", d, 32'hA5A5_0001);
    do_reset();
    chk("R1", "reset clears halt", {31'd0, halted}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_step_gate();
    t_arith();
    t_branch();
    t_trap_io();
    t_halt_sticky();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule